// File: doc/BRIEF.md
# X-Indexed Bus Cycle Sequencer

This block replays, one bus cycle per clock, the exact memory traffic that a small 8-bit processor makes when it runs one instruction in X-indexed addressing mode. A pulse on `start` loads the program counter and the X, Y, D and stack pointer values. The sequencer then fetches the instruction bytes and forms the effective address as X plus an unsigned 8-bit offset. It steps through the instruction's reads, writes and idle cycles, and on the last edge it updates the register outputs and the next program counter.

The bus is a 16-bit `addr`, a `rw` line (1 = read, 0 = write) and `wdata`. Read data on `rdata` is taken at the end of each cycle. Idle cycles drive `$FFFF` as a read, and their data is thrown away. A `$1A` first byte is a page prefix: it adds one fetch cycle and selects the second opcode page. Supported classes are 16-bit loads, 16-bit stores, 16-bit add, subtract and compare, subroutine call, bit set/clear and branch-on-bit. Flags are not produced.

Top module: `idx_bus_seq`

## Requirements
- R1: While not busy, and from reset, `busy` and `done` are 0 and the bus drives `addr`=$FFFF with `rw`=1.
- R2: Every instruction fetches its opcode at the current PC, or at PC+1 after a $1A prefix fetched at PC. It then fetches the offset at the next address and makes one idle $FFFF read. The effective address is X plus the zero-extended offset, modulo 2^16.
- R3: Loads read the high byte at the effective address and then the low byte at the next address. Opcodes: $EC loads D, $EE loads X, $1A $EE loads Y. A load takes 5 cycles, or 6 with the prefix.
- R4: Stores write the high byte at the effective address and then the low byte at the next address. Opcodes: $ED stores D, $AF stores SP, $EF stores X, $1A $EF stores Y. A store takes 5 cycles, or 6 with the prefix. `rw` is 0 only in write cycles.
- R5: $E3 (add to D), $A3 (subtract from D) and $AC (compare X) read two operand bytes and then make an idle $FFFF read, 6 cycles in all. $1A $A3 (compare D) and $1A $AC (compare Y) do the same in 7 cycles. Add and subtract write D modulo 2^16. Compares change no register.
- R6: $AD (call) takes 6 cycles. Cycle 4 reads the effective address. Cycle 5 writes the low byte of the return address (PC+2) at SP. Cycle 6 writes its high byte at SP-1. The new PC is the effective address and SP drops by 2.
- R7: $1C (bit set) and $1D (bit clear) take 7 cycles. After the idle read they read the operand at the effective address and the mask at PC+2, make an idle $FFFF read, then write back operand OR mask (set) or operand AND NOT mask (clear). The next PC is PC+3.
- R8: $1E (branch if bits set) and $1F (branch if bits clear) take 7 cycles. After the idle read they read the operand at the effective address, the mask at PC+2 and the displacement at PC+3, then make an idle $FFFF read. They make no write.
- R9: For branch-on-bit, the next PC is PC+4, plus the sign-extended displacement when the branch is taken. Bits-clear is taken when operand AND mask is 0. Bits-set is taken when NOT operand AND mask is 0.
- R10: Any other opcode, with or without the prefix, ends after its opcode fetch. The PC moves past the bytes fetched and no other register changes.
- R11: `done` pulses high for exactly one cycle, in the cycle after the last bus cycle. `busy` is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an instruction (sampled while idle) |
| pc_i | input | 16 | Program counter at start |
| x_i | input | 16 | X register at start |
| y_i | input | 16 | Y register at start |
| d_i | input | 16 | D accumulator at start |
| sp_i | input | 16 | Stack pointer at start |
| rdata | input | 8 | Read data for the current bus cycle |
| addr | output | 16 | Bus address |
| rw | output | 1 | 1 = read, 0 = write |
| wdata | output | 8 | Write data |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_o | output | 16 | Program counter after the instruction |
| x_o | output | 16 | X register |
| y_o | output | 16 | Y register |
| d_o | output | 16 | D accumulator |
| sp_o | output | 16 | Stack pointer |

## Verification
The assertions assume three things about the inputs. `start` is raised only while the sequencer is idle. `rdata` holds a known value for the whole of every read cycle. The stack pointer move they check comes only from a completed call. The bench meets these by pulsing `start` for one clock between instructions, after `done`. It also serves `rdata` from a combinational memory model that returns a fixed filler byte outside the program and operand windows. Each scenario compares every bus cycle against a trace built by hand from the requirements.

// File: rtl/idx_bus_seq.sv
module idx_bus_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] pc_i,
  input  logic [15:0] x_i,
  input  logic [15:0] y_i,
  input  logic [15:0] d_i,
  input  logic [15:0] sp_i,
  input  logic [7:0]  rdata,
  output logic [15:0] addr,
  output logic        rw,
  output logic [7:0]  wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc_o,
  output logic [15:0] x_o,
  output logic [15:0] y_o,
  output logic [15:0] d_o,
  output logic [15:0] sp_o
);
  localparam logic [7:0]  PREFIX = 8'h1A;
  localparam logic [15:0] IDLE_A = 16'hFFFF;

  typedef enum logic [2:0] {K_UNK, K_LD, K_ST, K_AR, K_CALL, K_BIT, K_BRB} kind_t;

  function automatic kind_t classify(input logic p, input logic [7:0] b);
    case (b)
      8'hEE, 8'hEF: classify = (b == 8'hEE) ? K_LD : K_ST;
      8'hA3, 8'hAC: classify = K_AR;
      8'hEC:        classify = p ? K_UNK : K_LD;
      8'hED, 8'hAF: classify = p ? K_UNK : K_ST;
      8'hE3:        classify = p ? K_UNK : K_AR;
      8'hAD:        classify = p ? K_UNK : K_CALL;
      8'h1C, 8'h1D: classify = p ? K_UNK : K_BIT;
      8'h1E, 8'h1F: classify = p ? K_UNK : K_BRB;
      default:      classify = K_UNK;
    endcase
  endfunction

  logic        pg;
  logic [2:0]  j;
  logic [7:0]  op, hi, mk, rel;
  logic [15:0] ea, pc, x, y, d, sp;

  kind_t       kind;
  logic [15:0] pb, ret, stv;
  logic [2:0]  endj;
  logic [7:0]  bitres;
  logic        taken, last;

  assign kind   = classify(pg, op);
  assign pb     = pc + {15'd0, pg};
  assign ret    = pb + 16'd2;
  assign stv    = (op == 8'hED) ? d : (op == 8'hAF) ? sp : pg ? y : x;
  assign bitres = op[0] ? (hi & ~mk) : (hi | mk);
  assign taken  = op[0] ? ((hi & mk) == 8'h00) : ((~hi & mk) == 8'h00);
  assign endj   = (kind == K_LD || kind == K_ST) ? 3'd4 :
                  (kind == K_AR || kind == K_CALL) ? 3'd5 : 3'd6;
  assign last   = busy && j != 3'd0 && j == endj;

  assign pc_o = pc;
  assign x_o  = x;
  assign y_o  = y;
  assign d_o  = d;
  assign sp_o = sp;

  always_comb begin
    addr  = IDLE_A;
    rw    = 1'b1;
    wdata = 8'h00;
    if (busy) begin
      case (j)
        3'd0: addr = pb;
        3'd1: addr = pb + 16'd1;
        3'd3: begin
          addr = ea;
          if (kind == K_ST) begin rw = 1'b0; wdata = stv[15:8]; end
        end
        3'd4: case (kind)
          K_ST:         begin addr = ea + 16'd1; rw = 1'b0; wdata = stv[7:0]; end
          K_CALL:       begin addr = sp; rw = 1'b0; wdata = ret[7:0]; end
          K_BIT, K_BRB: addr = pb + 16'd2;
          default:      addr = ea + 16'd1;
        endcase
        3'd5: case (kind)
          K_CALL:  begin addr = sp - 16'd1; rw = 1'b0; wdata = ret[15:8]; end
          K_BRB:   addr = pb + 16'd3;
          default: addr = IDLE_A;
        endcase
        3'd6: if (kind == K_BIT) begin addr = ea; rw = 1'b0; wdata = bitres; end
        default: addr = IDLE_A;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; pg <= 1'b0; j <= 3'd0;
      op <= 8'h00; hi <= 8'h00; mk <= 8'h00; rel <= 8'h00; ea <= 16'h0000;
      pc <= 16'h0000; x <= 16'h0000; y <= 16'h0000; d <= 16'h0000; sp <= 16'h0000;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; j <= 3'd0; pg <= 1'b0;
          pc <= pc_i; x <= x_i; y <= y_i; d <= d_i; sp <= sp_i;
        end
      end else begin
        j <= j + 3'd1;
        case (j)
          3'd0: if (!pg && rdata == PREFIX) begin
                  pg <= 1'b1; j <= 3'd0;
                end else begin
                  op <= rdata;
                  if (classify(pg, rdata) == K_UNK) begin
                    busy <= 1'b0; done <= 1'b1; j <= 3'd0; pc <= pb + 16'd1;
                  end
                end
          3'd1: ea <= x + {8'h00, rdata};
          3'd3: hi <= rdata;
          3'd4: begin
                  mk <= rdata;
                  if (kind == K_LD) begin
                    if (pg)                y <= {hi, rdata};
                    else if (op == 8'hEC)  d <= {hi, rdata};
                    else                   x <= {hi, rdata};
                  end
                end
          3'd5: rel <= rdata;
          default: ;
        endcase
        if (last) begin
          busy <= 1'b0; done <= 1'b1; j <= 3'd0;
          case (kind)
            K_CALL: begin pc <= ea; sp <= sp - 16'd2; end
            K_BIT:  pc <= pb + 16'd3;
            K_BRB:  pc <= pb + 16'd4 + (taken ? {{8{rel[7]}}, rel} : 16'h0000);
            default: pc <= pb + 16'd2;
          endcase
          if (kind == K_AR && !pg && op == 8'hE3) d <= d + {hi, mk};
          if (kind == K_AR && !pg && op == 8'hA3) d <= d - {hi, mk};
        end
      end
    end
  end

  p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (addr == 16'hFFFF && rw));
  p_step_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> j <= 3'd6);
  p_write_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rw |-> (busy && j >= 3'd3));
  p_sp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && sp != $past(sp)) |-> sp == $past(sp) - 16'd2);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: tb/test_idx_bus_seq.sv
module test_idx_bus_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] pc_i = 0, x_i = 0, y_i = 0, d_i = 0, sp_i = 0;
  logic [7:0]  rdata;
  logic [15:0] addr, pc_o, x_o, y_o, d_o, sp_o;
  logic        rw, busy, done;
  logic [7:0]  wdata;

  always #10 clk = ~clk;

  idx_bus_seq i_idx_bus_seq (.clk(clk), .rst_n(rst_n), .start(start), .pc_i(pc_i),
    .x_i(x_i), .y_i(y_i), .d_i(d_i), .sp_i(sp_i), .rdata(rdata), .addr(addr),
    .rw(rw), .wdata(wdata), .busy(busy), .done(done), .pc_o(pc_o), .x_o(x_o),
    .y_o(y_o), .d_o(d_o), .sp_o(sp_o));

  logic [15:0] pbase = 16'h8000, dbase = 16'h2000, po, dof;
  logic [7:0]  prog [0:7];
  logic [7:0]  dat  [0:1];
  assign po  = addr - pbase;
  assign dof = addr - dbase;
  always_comb begin
    rdata = 8'hA5;
    if (po < 16'd8)       rdata = prog[po[2:0]];
    else if (dof < 16'd2) rdata = dat[dof[0]];
  end

  int checks = 0, fails = 0, cyc = 0, n = 0;
  logic [15:0] e_a [0:7];
  logic        e_w [0:7];
  logic [7:0]  e_d [0:7];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic add(input logic [15:0] a, input logic w, input logic [7:0] dv);
    e_a[n] = a; e_w[n] = w; e_d[n] = dv; n++;
  endtask

  task automatic setup(input logic [15:0] x, y, d, sp, db);
    pc_i = 16'h8000; x_i = x; y_i = y; d_i = d; sp_i = sp; dbase = db; n = 0;
    for (int i = 0; i < 8; i++) prog[i] = 8'h00;
  endtask

  task automatic run(input string tag);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < n; i++) begin
      check({tag, " bus"}, {7'd0, rw, addr, rw ? 8'h00 : wdata},
            {7'd0, !e_w[i], e_a[i], e_w[i] ? e_d[i] : 8'h00});
      @(negedge clk);
    end
    check({tag, " R11 done"}, {30'd0, done, busy}, {30'd0, 1'b1, 1'b0});
    @(negedge clk);
    check({tag, " R11 pulse"}, {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 reset", {13'd0, busy, done, rw, addr}, {13'd0, 1'b0, 1'b0, 1'b1, 16'hFFFF});
  endtask

  task automatic t_ldy;
    setup(16'h2000, 16'h0000, 16'h1111, 16'h01FF, 16'h2010);
    prog[0] = 8'h1A; prog[1] = 8'hEE; prog[2] = 8'h10; dat[0] = 8'h12; dat[1] = 8'h34;
    add(16'h8000,0,0); add(16'h8001,0,0); add(16'h8002,0,0); add(16'hFFFF,0,0);
    add(16'h2010,0,0); add(16'h2011,0,0);
    run("R3 ldy");
    check("R3 y", y_o, 16'h1234); check("R9 pc", pc_o, 16'h8003);
    check("R3 d kept", d_o, 16'h1111);
  endtask

  task automatic t_ldd_wrap;
    setup(16'hFFF8, 16'h0000, 16'h0000, 16'h01FF, 16'h0008);
    prog[0] = 8'hEC; prog[1] = 8'h10; dat[0] = 8'h9A; dat[1] = 8'hBC;
    add(16'h8000,0,0); add(16'h8001,0,0); add(16'hFFFF,0,0); add(16'h0008,0,0); add(16'h0009,0,0);
    run("R2 ldd wrap");
    check("R3 d", d_o, 16'h9ABC); check("R9 pc", pc_o, 16'h8002);
  endtask

  task automatic t_sty;
    setup(16'h2000, 16'hBEEF, 16'h0000, 16'h01FF, 16'h3000);
    prog[0] = 8'h1A; prog[1] = 8'hEF; prog[2] = 8'h05;
    add(16'h8000,0,0); add(16'h8001,0,0); add(16'h8002,0,0); add(16'hFFFF,0,0);
    add(16'h2005,1,8'hBE); add(16'h2006,1,8'hEF);
    run("R4 sty");
    check("R9 pc", pc_o, 16'h8003);
  endtask

  task automatic t_std_sts;
    setup(16'h4000, 16'h0000, 16'hA55A, 16'h01F0, 16'h3000);
    prog[0] = 8'hED; prog[1] = 8'h00;
    add(16'h8000,0,0); add(16'h8001,0,0); add(16'hFFFF,0,0);
    add(16'h4000,1,8'hA5); add(16'h4001,1,8'h5A);
    run("R4 std");
    setup(16'h4000, 16'h0000, 16'hA55A, 16'h01F0, 16'h3000);
    prog[0] = 8'hAF; prog[1] = 8'h01;
    add(16'h8000,0,0); add(16'h8001,0,0); add(16'hFFFF,0,0);
    add(16'h4001,1,8'h01); add(16'h4002,1,8'hF0);
    run("R4 sts");
    check("R4 sp kept", sp_o, 16'h01F0);
  endtask

  task automatic t_call;
    setup(16'h3000, 16'h0000, 16'h0000, 16'h01FF, 16'h5000);
    prog[0] = 8'hAD; prog[1] = 8'h20;
    add(16'h8000,0,0); add(16'h8001,0,0); add(16'hFFFF,0,0); add(16'h3020,0,0);
    add(16'h01FF,1,8'h02); add(16'h01FE,1,8'h80);
    run("R6 call");
    check("R6 pc", pc_o, 16'h3020); check("R6 sp", sp_o, 16'h01FD);
  endtask

  task automatic t_bitop(input logic [7:0] opc, mask, opnd, res);
    setup(16'h2000, 16'h0000, 16'h0000, 16'h01FF, 16'h2004);
    prog[0] = opc; prog[1] = 8'h04; prog[2] = mask; dat[0] = opnd;
    add(16'h8000,0,0); add(16'h8001,0,0); add(16'hFFFF,0,0); add(16'h2004,0,0);
    add(16'h8002,0,0); add(16'hFFFF,0,0); add(16'h2004,1,res);
    run("R7 bitop");
    check("R7 pc", pc_o, 16'h8003);
  endtask

  task automatic t_brb(input logic [7:0] opc, mask, opnd, disp, input logic [15:0] npc);
    setup(16'h2000, 16'h0000, 16'h0000, 16'h01FF, 16'h2004);
    prog[0] = opc; prog[1] = 8'h04; prog[2] = mask; prog[3] = disp; dat[0] = opnd;
    add(16'h8000,0,0); add(16'h8001,0,0); add(16'hFFFF,0,0); add(16'h2004,0,0);
    add(16'h8002,0,0); add(16'h8003,0,0); add(16'hFFFF,0,0);
    run("R8 brb");
    check("R9 branch pc", pc_o, npc);
  endtask

  task automatic t_arith(input logic pre, input logic [7:0] opc,
                         input logic [15:0] dstart, dend, input logic [15:0] npc);
    setup(16'h2000, 16'h7777, dstart, 16'h01FF, 16'h2000);
    dat[0] = 8'h01; dat[1] = 8'h23;
    if (pre) begin
      prog[0] = 8'h1A; prog[1] = opc; prog[2] = 8'h00;
      add(16'h8000,0,0); add(16'h8001,0,0); add(16'h8002,0,0);
    end else begin
      prog[0] = opc; prog[1] = 8'h00;
      add(16'h8000,0,0); add(16'h8001,0,0);
    end
    add(16'hFFFF,0,0); add(16'h2000,0,0); add(16'h2001,0,0); add(16'hFFFF,0,0);
    run("R5 arith");
    check("R5 d", d_o, dend); check("R5 y kept", y_o, 16'h7777);
    check("R5 x kept", x_o, 16'h2000); check("R9 pc", pc_o, npc);
  endtask

  task automatic t_unknown;
    setup(16'h2000, 16'h3333, 16'h4444, 16'h01FF, 16'h2000);
    prog[0] = 8'h01;
    add(16'h8000,0,0);
    run("R10 unk");
    check("R10 pc", pc_o, 16'h8001);
    check("R10 regs", {x_o, y_o}, {16'h2000, 16'h3333});
    setup(16'h2000, 16'h3333, 16'h4444, 16'h01FF, 16'h2000);
    prog[0] = 8'h1A; prog[1] = 8'hEC;
    add(16'h8000,0,0); add(16'h8001,0,0);
    run("R10 unk pre");
    check("R10 pc pre", pc_o, 16'h8002);
    check("R10 regs pre", {d_o, sp_o}, {16'h4444, 16'h01FF});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ldy();
    t_ldd_wrap();
    t_sty();
    t_std_sts();
    t_call();
    t_bitop(8'h1C, 8'h0F, 8'hA0, 8'hAF);
    t_bitop(8'h1D, 8'h31, 8'hF3, 8'hC2);
    t_brb(8'h1F, 8'h0C, 8'h80, 8'hF0, 16'h7FF4);
    t_brb(8'h1F, 8'h0C, 8'h84, 8'hF0, 16'h8004);
    t_brb(8'h1E, 8'h0E, 8'h0C, 8'h10, 16'h8004);
    t_brb(8'h1E, 8'h0E, 8'h0F, 8'h10, 16'h8014);
    t_arith(1'b0, 8'hE3, 16'h1000, 16'h1123, 16'h8002);
    t_arith(1'b0, 8'hA3, 16'h1000, 16'h0EDD, 16'h8002);
    t_arith(1'b1, 8'hAC, 16'h1000, 16'h1000, 16'h8003);
    t_unknown();
    t_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule